// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Mode and Level Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on separate, unrelated clocks. A write enable qualifies each write clock edge and a read enable qualifies each read clock edge. The storage depth is a parameter; its default is 1024 words.

The output behaviour is chosen while master reset is asserted and is then held. In standard mode the block reports full and empty, and a read copies the head word into a registered output on the read clock edge that accepts it. In fall-through mode the block reports input-ready and output-ready instead, and the head word is placed on the output without any read request. In that mode a read consumes the word already shown. Three level flags come on top of these: almost-full and almost-empty, whose thresholds come from a separate configuration block as input ports, and half-full. A partial reset empties the buffer but keeps the selected mode. A retransmit request moves reading back to the first memory location so that stored data can be read again.

Top module: `dualModeFifo`

## Requirements
- R1: While master reset is high, both pointers are zero and dataOut is all zeros. After release the block is empty: in standard mode fullOrInReady=0 and emptyOrOutReady=1; in fall-through mode fullOrInReady=1 and emptyOrOutReady=0.
- R2: The level of modeSel on the write and read clock edges during master reset selects the mode (1 = fall-through, 0 = standard). Changes of modeSel after release have no effect until the next master reset.
- R3: Partial reset clears both pointers and dataOut, leaving the block empty. The mode selected by the last master reset is kept.
- R4: In standard mode, fullOrInReady is high exactly when DEPTH words are stored, and emptyOrOutReady is high exactly when no unread word remains. An accepted read places the head word on dataOut at the read clock edge that accepts it.
- R5: In fall-through mode, the head word appears on dataOut with no read. emptyOrOutReady (output-ready) is high while a valid word is shown. fullOrInReady (input-ready) is high while the memory has a free location. Because the output stage holds one more word, the total capacity is DEPTH+1. A read consumes the shown word and presents the next one.
- R6: almostFull is high when the number of free memory locations is at most fullOffset, and low when it is larger.
- R7: almostEmpty is high when the number of stored words is at most emptyOffset, and low when it is larger. In fall-through mode the word held on the output counts as stored.
- R8: halfFull is high when the number of words in memory is greater than DEPTH/2.
- R9: A retransmit pulse on the read clock rewinds the read pointer to memory location 0, so the following reads return the data from location 0 onward.
- R10: A write while the memory is full is ignored. A standard-mode read while empty leaves dataOut and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| masterRst | input | 1 | Master reset, active high, asynchronous; mode is sampled while high |
| partRst | input | 1 | Partial reset, active high, asynchronous; mode kept |
| modeSel | input | 1 | Mode choice sampled during master reset (1 = fall-through) |
| retransmit | input | 1 | Read-clock pulse that rewinds reading to location 0 |
| wrEn | input | 1 | Write enable |
| dataIn | input | 9 | Write data |
| rdEn | input | 1 | Read enable |
| dataOut | output | 9 | Read data |
| fullOffset | input | log2(DEPTH) | Almost-full threshold in free locations |
| emptyOffset | input | log2(DEPTH) | Almost-empty threshold in stored words |
| fullOrInReady | output | 1 | Full (standard) or input-ready (fall-through) |
| emptyOrOutReady | output | 1 | Empty (standard) or output-ready (fall-through) |
| almostFull | output | 1 | Few free locations remain |
| almostEmpty | output | 1 | Few words are stored |
| halfFull | output | 1 | More than half of memory occupied |

## Verification
The bench sweeps every fill level of a 16-deep instance in both modes, one word at a time, and then drains it the same way, comparing each flag with the thresholds computed from the level. A design that counts the output-stage word in the wrong domain shifts input-ready and almost-empty by one at the top or bottom level. A design that mis-compares at a threshold shows up at the exact level where a flag should toggle. Other stimuli are a write into a full buffer and a read from an empty one; a design that advances a pointer on those would corrupt the later data order or flags. Further checks cover a retransmit after a full drain, a partial reset followed by a write (which would show a lost mode), and a modeSel change after reset.

// File: rtl/fifoPkg.sv
`timescale 1ns/1ps
package fifoPkg;
  // strobes from the pointer/flag control to the storage datapath
  typedef struct packed {
    logic wrStrobe;  // write dataIn to wrAddr on wClk
    logic loadOut;   // copy memory[rdAddr] into output register on rClk
  } fifoStrobeT;
endpackage

// File: rtl/grayPtrSync.sv
`timescale 1ns/1ps
module grayPtrSync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the XOR of itself and all higher bits
  always_comb begin
    for (int i = 0; i < W; i++) binOut[i] = ^(stage2 >> i);
  end
endmodule

// File: rtl/fifoCtrl.sv
`timescale 1ns/1ps
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wClk,
  input  logic          rClk,
  input  logic          masterRst,
  input  logic          partRst,
  input  logic          modeSel,
  input  logic          retransmit,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] fullOffset,
  input  logic [AW-1:0] emptyOffset,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output fifoStrobeT    strobes,
  output logic          fwftModeR,
  output logic          fullOrInReady,
  output logic          emptyOrOutReady,
  output logic          almostFull,
  output logic          almostEmpty,
  output logic          halfFull
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic rstAny;
  assign rstAny = masterRst | partRst;

  // mode latch, one copy per clock domain, loaded only during master reset
  logic fwftW, fwftR;
  always_ff @(posedge wClk) if (masterRst) fwftW <= modeSel;
  always_ff @(posedge rClk) if (masterRst) fwftR <= modeSel;
  assign fwftModeR = fwftR;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrPtr, wrPtrNext, wrGray, rdSyncBin, wCount, freeCnt;
  logic memFull, wrAccept;

  grayPtrSync #(.W(PW)) uRdToWr (
    .clk(wClk), .rst(rstAny), .grayIn(rdGray), .binOut(rdSyncBin)
  );

  always_comb begin
    wCount    = wrPtr - rdSyncBin;
    freeCnt   = DEPTH_P - wCount;
    memFull   = (wCount == DEPTH_P);
    wrAccept  = wrEn & ~memFull;
    wrPtrNext = wrPtr + {{AW{1'b0}}, wrAccept};
  end

  always_ff @(posedge wClk or posedge rstAny) begin
    if (rstAny) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else begin
      wrPtr  <= wrPtrNext;
      wrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  assign fullOrInReady = fwftW ? ~memFull : memFull;
  assign almostFull    = (freeCnt <= {1'b0, fullOffset});
  assign halfFull      = (wCount > HALF_P);
  assign wrAddr        = wrPtr[AW-1:0];

  // ---------------- read domain ----------------
  logic [PW-1:0] rdPtr, rdPtrNext, rdGray, wrSyncBin, rCount;
  logic [PW:0]   wordCnt;
  logic memEmpty, outValid, outValidNext, consume, loadOut;

  grayPtrSync #(.W(PW)) uWrToRd (
    .clk(rClk), .rst(rstAny), .grayIn(wrGray), .binOut(wrSyncBin)
  );

  always_comb begin
    rCount   = wrSyncBin - rdPtr;
    memEmpty = (rCount == '0);
    consume  = fwftR & rdEn & outValid;
    if (fwftR) loadOut = ~memEmpty & (~outValid | consume);
    else       loadOut = rdEn & ~memEmpty;
    if (retransmit) begin
      loadOut      = 1'b0;
      rdPtrNext    = '0;
      outValidNext = 1'b0;
    end else begin
      rdPtrNext    = rdPtr + {{AW{1'b0}}, loadOut};
      outValidNext = fwftR & (loadOut | (outValid & ~consume));
    end
    wordCnt = {1'b0, rCount} + {{PW{1'b0}}, fwftR & outValid};
  end

  always_ff @(posedge rClk or posedge rstAny) begin
    if (rstAny) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      rdPtr    <= rdPtrNext;
      rdGray   <= rdPtrNext ^ (rdPtrNext >> 1);
      outValid <= outValidNext;
    end
  end

  assign emptyOrOutReady = fwftR ? outValid : memEmpty;
  assign almostEmpty     = (wordCnt <= {2'b00, emptyOffset});
  assign rdAddr          = rdPtr[AW-1:0];

  assign strobes.wrStrobe = wrAccept;
  assign strobes.loadOut  = loadOut;

  // ---------------- assertions ----------------
  // R10: occupancy seen by the writer never exceeds the memory size
  assert_no_overflow_R10: assert property (@(posedge wClk) disable iff (rstAny)
    wCount <= DEPTH_P);
  // R10: occupancy seen by the reader never exceeds the memory size
  assert_no_underflow_R10: assert property (@(posedge rClk) disable iff (rstAny)
    rCount <= DEPTH_P);
  // R2: latched mode is frozen once master reset is released
  assert_mode_held_R2: assert property (@(posedge rClk) disable iff (rstAny)
    $stable(fwftR));
  // R5: the output stage only becomes valid from a non-empty memory
  assert_fall_through_source_R5: assert property (@(posedge rClk) disable iff (rstAny)
    (fwftR && $rose(outValid)) |-> $past(!memEmpty));
  // R4: the write pointer crosses domains changing at most one Gray bit per edge
  assert_gray_step_R4: assert property (@(posedge wClk) disable iff (rstAny)
    $countones(wrGray ^ $past(wrGray)) <= 1);
endmodule

// File: rtl/fifoData.sv
`timescale 1ns/1ps
module fifoData
  import fifoPkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wClk,
  input  logic          rClk,
  input  logic          rstAny,
  input  fifoStrobeT    strobes,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] outReg;

  always_ff @(posedge wClk) begin
    if (strobes.wrStrobe) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge rClk or posedge rstAny) begin
    if (rstAny)               outReg <= '0;
    else if (strobes.loadOut) outReg <= mem[rdAddr];
  end

  assign dataOut = outReg;
endmodule

// File: rtl/dualModeFifo.sv
`timescale 1ns/1ps
module dualModeFifo
  import fifoPkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wClk,
  input  logic          rClk,
  input  logic          masterRst,
  input  logic          partRst,
  input  logic          modeSel,
  input  logic          retransmit,
  input  logic          wrEn,
  input  logic [DW-1:0] dataIn,
  input  logic          rdEn,
  output logic [DW-1:0] dataOut,
  input  logic [AW-1:0] fullOffset,
  input  logic [AW-1:0] emptyOffset,
  output logic          fullOrInReady,
  output logic          emptyOrOutReady,
  output logic          almostFull,
  output logic          almostEmpty,
  output logic          halfFull
);
  fifoStrobeT    strobes;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftModeR;

  fifoCtrl #(.DEPTH(DEPTH), .AW(AW)) uCtrl (
    .wClk(wClk), .rClk(rClk), .masterRst(masterRst), .partRst(partRst),
    .modeSel(modeSel), .retransmit(retransmit), .wrEn(wrEn), .rdEn(rdEn),
    .fullOffset(fullOffset), .emptyOffset(emptyOffset),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes), .fwftModeR(fwftModeR),
    .fullOrInReady(fullOrInReady), .emptyOrOutReady(emptyOrOutReady),
    .almostFull(almostFull), .almostEmpty(almostEmpty), .halfFull(halfFull)
  );

  fifoData #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) uData (
    .wClk(wClk), .rClk(rClk), .rstAny(masterRst | partRst), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .dataOut(dataOut)
  );

  // R10: a standard-mode read while empty leaves the output untouched
  assert_empty_read_hold_R10: assert property (@(posedge rClk)
    disable iff (masterRst | partRst)
    (!fwftModeR && rdEn && emptyOrOutReady && !retransmit) |=> $stable(dataOut));
endmodule

// File: tb/tb_dualModeFifo.sv
`timescale 1ns/1ps
module tb_dualModeFifo;
  localparam int DW = 9;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int M = 3;  // fullOffset
  localparam int N = 2;  // emptyOffset

  logic wClk = 0, rClk = 0;
  logic masterRst = 1, partRst = 0, modeSel = 0, retransmit = 0;
  logic wrEn = 0, rdEn = 0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic [AW-1:0] fullOffset = AW'(M), emptyOffset = AW'(N);
  logic fullOrInReady, emptyOrOutReady, almostFull, almostEmpty, halfFull;

  int checks = 0, errors = 0;

  dualModeFifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wClk(wClk), .rClk(rClk), .masterRst(masterRst), .partRst(partRst),
    .modeSel(modeSel), .retransmit(retransmit), .wrEn(wrEn), .dataIn(dataIn),
    .rdEn(rdEn), .dataOut(dataOut), .fullOffset(fullOffset), .emptyOffset(emptyOffset),
    .fullOrInReady(fullOrInReady), .emptyOrOutReady(emptyOrOutReady),
    .almostFull(almostFull), .almostEmpty(almostEmpty), .halfFull(halfFull)
  );

  always #2 wClk = ~wClk;
  initial begin #1; forever #2 rClk = ~rClk; end

  function automatic int val(int i);
    return (i * 37 + 5) % 512;
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rClk);
  endtask

  task automatic doMasterReset(logic mode);
    @(negedge wClk);
    masterRst = 1; modeSel = mode;
    repeat (3) @(negedge wClk);
    masterRst = 0;
    settle();
  endtask

  task automatic doPartReset();
    @(negedge wClk);
    partRst = 1;
    repeat (3) @(negedge wClk);
    partRst = 0;
    settle();
  endtask

  task automatic writeWord(int d);
    @(negedge wClk);
    wrEn = 1; dataIn = DW'(d);
    @(negedge wClk);
    wrEn = 0;
  endtask

  task automatic readWord();
    @(negedge rClk);
    rdEn = 1;
    @(negedge rClk);
    rdEn = 0;
  endtask

  // standard-mode flag check for a given stored count
  task automatic stdFlags(string tag, int cnt);
    check({tag, " R4 full"}, int'(fullOrInReady), int'(cnt == DEPTH));
    check({tag, " R4 empty"}, int'(emptyOrOutReady), int'(cnt == 0));
    check({tag, " R6 almostFull"}, int'(almostFull), int'(DEPTH - cnt <= M));
    check({tag, " R7 almostEmpty"}, int'(almostEmpty), int'(cnt <= N));
    check({tag, " R8 halfFull"}, int'(halfFull), int'(cnt > DEPTH / 2));
  endtask

  initial begin
    // watchdog
    repeat (100000) @(posedge wClk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // ---------- standard mode ----------
    doMasterReset(1'b0);
    check("R1 dataOut after master reset", int'(dataOut), 0);
    stdFlags("R1 reset", 0);

    for (int k = 1; k <= DEPTH; k++) begin
      writeWord(val(k - 1));
      settle();
      stdFlags("fill", k);
    end
    writeWord(9'h1AA);  // R10: ignored while full
    settle();
    stdFlags("R10 overflow", DEPTH);

    for (int j = 0; j < DEPTH; j++) begin
      readWord();
      settle();
      check("R4 read data", int'(dataOut), val(j));
      stdFlags("drain", DEPTH - 1 - j);
    end
    readWord();  // R10: ignored while empty
    settle();
    check("R10 empty read keeps dataOut", int'(dataOut), val(DEPTH - 1));
    stdFlags("R10 underflow", 0);

    // R9: retransmit rewinds to location 0; all 16 locations hold the data
    @(negedge rClk); retransmit = 1;
    @(negedge rClk); retransmit = 0;
    settle();
    stdFlags("R9 after retransmit", DEPTH);
    for (int j = 0; j < 4; j++) begin
      readWord();
      settle();
      check("R9 resent data", int'(dataOut), val(j));
    end

    // R3: partial reset empties, keeps standard mode
    doPartReset();
    check("R3 dataOut cleared", int'(dataOut), 0);
    stdFlags("R3 partial reset", 0);
    writeWord(9'h0C3);
    settle();
    check("R3 standard mode kept (no fall-through)", int'(dataOut), 0);
    readWord();
    settle();
    check("R3 read after partial reset", int'(dataOut), 9'h0C3);

    // ---------- fall-through mode ----------
    doMasterReset(1'b1);
    modeSel = 0;  // R2: ignored after release
    check("R1 fwft dataOut", int'(dataOut), 0);
    check("R1 fwft inReady", int'(fullOrInReady), 1);
    check("R1 fwft outReady", int'(emptyOrOutReady), 0);

    for (int k = 1; k <= DEPTH + 1; k++) begin
      writeWord(val(k + 20));
      settle();
      check("R5 outReady", int'(emptyOrOutReady), 1);
      check("R5 head shown without read", int'(dataOut), val(21));
      check("R5 inReady", int'(fullOrInReady), int'((k - 1) < DEPTH));
      check("R6 fwft almostFull", int'(almostFull), int'(DEPTH - (k - 1) <= M));
      check("R7 fwft almostEmpty", int'(almostEmpty), int'(k <= N));
      check("R8 fwft halfFull", int'(halfFull), int'((k - 1) > DEPTH / 2));
    end
    writeWord(9'h155);  // R10: ignored, memory full
    settle();
    check("R10 fwft write ignored inReady", int'(fullOrInReady), 0);

    for (int j = 0; j <= DEPTH; j++) begin
      readWord();
      settle();
      check("R5 outReady after read", int'(emptyOrOutReady), int'(DEPTH - j > 0));
      if (DEPTH - j > 0) check("R5 next head", int'(dataOut), val(j + 22));
      check("R7 fwft drain almostEmpty", int'(almostEmpty), int'(DEPTH - j <= N));
    end
    check("R2 mode held despite modeSel=0", int'(fullOrInReady), 1);

    // R3: partial reset keeps fall-through mode
    writeWord(9'h011);
    writeWord(9'h022);
    doPartReset();
    check("R3 fwft dataOut cleared", int'(dataOut), 0);
    check("R3 fwft inReady", int'(fullOrInReady), 1);
    check("R3 fwft outReady", int'(emptyOrOutReady), 0);
    writeWord(9'h099);
    settle();
    check("R3 fwft mode kept outReady", int'(emptyOrOutReady), 1);
    check("R3 fwft mode kept data", int'(dataOut), 9'h099);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule